// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block sits between an analog comparator and a small CPU. It takes the comparator's one-bit result and brings it into the clock domain through a chain of flops. It watches the synchronized value for the edge kind that software has chosen, and records a matching edge in a sticky flag. It requests an interrupt when that flag is armed by a local enable and by the CPU's global enable. A single 8-bit control/status register, reached through a plain write strobe and a combinational read port, holds the configuration and shows the live comparator level.

Two control lines go to the analog side. One powers the comparator down. The other switches the positive input from the pin to the internal reference. While the comparator is powered down, the synchronized level is frozen, so switching the comparator off or back on does not produce a spurious edge. Software clears the flag by writing a one to its bit. The flag is also cleared when the CPU takes the interrupt vector.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: The register's writable fields sit at fixed bits: bit 7 power-down, bit 6 reference select, bit 3 interrupt enable, bits 1:0 edge mode. Each field reads back the last value written.
- R2: Bit 2 always reads 0, and writing it has no effect.
- R3: Bit 5 reads the comparator level delayed by two clock edges. Writes to bit 5 have no effect.
- R4: Edge mode 2'b00 sets the flag (bit 4) on any change of the synchronized level. Mode 2'b10 sets it on a 1-to-0 change, and mode 2'b11 sets it on a 0-to-1 change. The flag is set one edge after the new level appears in bit 5.
- R5: Edge mode 2'b01 never sets the flag.
- R6: The flag stays set until it is cleared. Writing 1 to bit 4 clears it. Writing 0 to bit 4 leaves it unchanged.
- R7: A pulse on the vector-acknowledge input clears the flag.
- R8: The interrupt request is high exactly when the flag, the enable bit and the global enable input are all 1.
- R9: After reset, every writable bit and the flag are 0, the request is low, and both analog control outputs are low.
- R10: The power-down output follows bit 7, and the reference-select output follows bit 6.
- R11: When a qualifying edge and a clear (write-one or acknowledge) fall in the same cycle, the flag ends up set.
- R12: While bit 7 is 1, the synchronized level is held. A change on the comparator input during that time neither shows in bit 5 nor sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw_i | input | 1 | Asynchronous comparator result |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_ack_i | input | 1 | CPU took the comparator vector |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| cmp_pwrdn_o | output | 1 | Comparator power-down |
| ref_sel_o | output | 1 | Route internal reference to positive input |

## Verification
The assertions assume that the comparator input is the only asynchronous signal. They also assume that the write strobe, the acknowledge and the global enable change only between clock edges. The clear-by-write and clear-by-acknowledge properties are stated only for cycles with no pending edge event, because R11 gives a coinciding event priority. The bench drives every input on the falling clock edge. It changes the edge mode only while the comparator level is steady, and it lets the synchronizer settle before each new case. The collision test then aligns a clear with the event cycle on purpose.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
   localparam int unsigned REG_W = 8;

   // bit positions decoded by software
   localparam int unsigned B_PWRDN = 7;
   localparam int unsigned B_REFSEL = 6;
   localparam int unsigned B_LEVEL = 5;
   localparam int unsigned B_FLAG = 4;
   localparam int unsigned B_IE = 3;
   localparam int unsigned B_RSVD = 2;
   localparam int unsigned B_MODE = 0;
   localparam int unsigned MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      EDGE_ANY  = 2'b00,
      EDGE_NONE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_RISE = 2'b11
   } edge_mode_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("cmp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else if (!hold_i) chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else if (!hold_i) chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

   // R12
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> $stable(q_o));
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
   import cmp_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl_i,
   input  edge_mode_e mode_i,
   output logic       evt_o
);
   logic prev_q;
   logic rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else prev_q <= lvl_i;
   end

   assign rise = lvl_i & ~prev_q;
   assign fall = ~lvl_i & prev_q;

   always_comb begin
      unique case (mode_i)
         EDGE_ANY:  evt_o = rise | fall;
         EDGE_FALL: evt_o = fall;
         EDGE_RISE: evt_o = rise;
         default:   evt_o = 1'b0;
      endcase
   end

   // R4
   steady_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(lvl_i) |=> !evt_o || !$stable(lvl_i));
endmodule

// File: rtl/cmp_ctl_reg.sv
module cmp_ctl_reg
   import cmp_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic             ack_i,
   input  logic             evt_i,
   output logic             pwrdn_o,
   output logic             refsel_o,
   output logic             ie_o,
   output edge_mode_e       mode_o,
   output logic             flag_o
);
   logic clr;
   logic unused_wbits;

   assign clr = ack_i | (we_i & wdata_i[B_FLAG]);
   assign unused_wbits = ^{wdata_i[B_LEVEL], wdata_i[B_RSVD]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwrdn_o  <= 1'b0;
         refsel_o <= 1'b0;
         ie_o     <= 1'b0;
         mode_o   <= EDGE_ANY;
      end else if (we_i) begin
         pwrdn_o  <= wdata_i[B_PWRDN];
         refsel_o <= wdata_i[B_REFSEL];
         ie_o     <= wdata_i[B_IE];
         mode_o   <= edge_mode_e'(wdata_i[B_MODE +: MODE_W]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= 1'b0;
      else if (evt_i) flag_o <= 1'b1;
      else if (clr) flag_o <= 1'b0;
   end

   // R4 R11
   evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_o);
   // R7
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !evt_i) |=> !flag_o);
   // R6
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && wdata_i[B_FLAG] && !evt_i) |=> !flag_o);
   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !ack_i && !(we_i && wdata_i[B_FLAG])) |=> flag_o);
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
   import cmp_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmp_raw_i,
   input  logic       reg_we_i,
   input  logic [7:0] reg_wdata_i,
   output logic [7:0] reg_rdata_o,
   input  logic       irq_ack_i,
   input  logic       gie_i,
   output logic       irq_o,
   output logic       cmp_pwrdn_o,
   output logic       ref_sel_o
);
   generate
      if (REG_W != 8) begin : g_bad_w
         $error("cmp_irq_ctrl: register must be 8 bits");
      end
   endgenerate

   logic       lvl;
   logic       evt;
   logic       ie;
   logic       flag;
   edge_mode_e mode;

   cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (cmp_pwrdn_o),
      .d_i    (cmp_raw_i),
      .q_o    (lvl)
   );

   cmp_edge_det u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl),
      .mode_i (mode),
      .evt_o  (evt)
   );

   cmp_ctl_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (reg_we_i),
      .wdata_i  (reg_wdata_i),
      .ack_i    (irq_ack_i),
      .evt_i    (evt),
      .pwrdn_o  (cmp_pwrdn_o),
      .refsel_o (ref_sel_o),
      .ie_o     (ie),
      .mode_o   (mode),
      .flag_o   (flag)
   );

   always_comb begin
      reg_rdata_o                         = '0;
      reg_rdata_o[B_PWRDN]                = cmp_pwrdn_o;
      reg_rdata_o[B_REFSEL]               = ref_sel_o;
      reg_rdata_o[B_LEVEL]                = lvl;
      reg_rdata_o[B_FLAG]                 = flag;
      reg_rdata_o[B_IE]                   = ie;
      reg_rdata_o[B_MODE +: MODE_W]       = mode;
   end

   assign irq_o = flag & ie & gie_i;

   // R5
   rsvd_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && mode == EDGE_NONE && !reg_we_i) |=> !flag);
   // R12
   pwrdn_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_pwrdn_o && $past(cmp_pwrdn_o) && !flag) |=> !flag);
   // R8
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rdata_o[B_FLAG]) |-> !irq_o);
endmodule

// File: tb/test_cmp_irq_ctrl.sv
`timescale 1ns/1ps
module test_cmp_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_raw_i = 1'b0;
   logic       reg_we_i = 1'b0;
   logic [7:0] reg_wdata_i = '0;
   logic [7:0] reg_rdata_o;
   logic       irq_ack_i = 1'b0;
   logic       gie_i = 1'b0;
   logic       irq_o;
   logic       cmp_pwrdn_o;
   logic       ref_sel_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   cmp_irq_ctrl i_cmp_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .cmp_raw_i(cmp_raw_i),
      .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .irq_ack_i(irq_ack_i), .gie_i(gie_i), .irq_o(irq_o),
      .cmp_pwrdn_o(cmp_pwrdn_o), .ref_sel_o(ref_sel_o)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] v);
      reg_we_i = 1'b1;
      reg_wdata_i = v;
      tick();
      reg_we_i = 1'b0;
      reg_wdata_i = '0;
   endtask

   function automatic logic expect_evt(input int m, input logic a, input logic b);
      case (m)
         0: return a != b;
         2: return a & ~b;
         3: return ~a & b;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tick(2);
      // R9 reset state (bit 5 masked: level undefined by requirement)
      chk("R9 rdata", reg_rdata_o & 8'hDF, 8'h00);
      chk("R9 outs", {5'b0, irq_o, cmp_pwrdn_o, ref_sel_o}, 8'h00);
      rst_n = 1'b1;
      tick(2);

      // R1 R2 R3 R10: all ones; flag w1c, level stays 0, reserved stays 0
      wr(8'hFF);
      chk("R1 R2 R3 all-ones readback", reg_rdata_o, 8'hCB);
      chk("R10 pwrdn/refsel set", {6'b0, cmp_pwrdn_o, ref_sel_o}, 8'h03);
      wr(8'h4A);
      chk("R1 field mix", reg_rdata_o, 8'h4A);
      chk("R10 refsel only", {6'b0, cmp_pwrdn_o, ref_sel_o}, 8'h01);
      wr(8'h04);
      chk("R2 reserved write ignored", reg_rdata_o, 8'h00);

      // R3 level latency two edges
      cmp_raw_i = 1'b1;
      tick();
      chk("R3 level after 1 edge", {7'b0, reg_rdata_o[5]}, 8'h00);
      tick();
      chk("R3 level after 2 edges", {7'b0, reg_rdata_o[5]}, 8'h01);
      tick(3);

      // R4 R5 sweep: every mode x every level transition
      for (int m = 0; m < 4; m++) begin
         for (int t = 0; t < 4; t++) begin
            logic a, b;
            a = t[1];
            b = t[0];
            wr(8'h10 | 8'(m));
            cmp_raw_i = a;
            tick(4);
            wr(8'h10 | 8'(m));
            chk($sformatf("R4 R5 cleared m%0d %0d->%0d", m, a, b),
                {7'b0, reg_rdata_o[4]}, 8'h00);
            cmp_raw_i = b;
            tick(2);
            chk($sformatf("R4 R5 pre m%0d %0d->%0d", m, a, b),
                {7'b0, reg_rdata_o[4]}, 8'h00);
            tick();
            chk($sformatf("R4 R5 flag m%0d %0d->%0d", m, a, b),
                {7'b0, reg_rdata_o[4]}, {7'b0, expect_evt(m, a, b)});
            tick(2);
         end
      end

      // R6 sticky and w1c; raw is 1, mode 00
      wr(8'h10);
      cmp_raw_i = 1'b0;
      tick(6);
      chk("R6 sticky", {7'b0, reg_rdata_o[4]}, 8'h01);
      wr(8'h08);
      chk("R6 write0 keeps", {7'b0, reg_rdata_o[4]}, 8'h01);

      // R8 request gating (flag=1)
      for (int k = 0; k < 4; k++) begin
         wr(k[1] ? 8'h08 : 8'h00);
         gie_i = k[0];
         tick();
         chk($sformatf("R8 irq ie%0d gie%0d", k[1], k[0]),
             {7'b0, irq_o}, {7'b0, k[1] & k[0]});
      end
      wr(8'h18);
      chk("R6 write1 clears", {7'b0, reg_rdata_o[4]}, 8'h00);
      chk("R8 irq low after clear", {7'b0, irq_o}, 8'h00);

      // R7 ack clears; R11 ack collides with event
      cmp_raw_i = 1'b1;
      tick(4);
      chk("R7 flag up", {7'b0, irq_o}, 8'h01);
      cmp_raw_i = 1'b0;
      tick(2);
      irq_ack_i = 1'b1;
      tick();
      irq_ack_i = 1'b0;
      chk("R11 ack vs event", {7'b0, reg_rdata_o[4]}, 8'h01);
      irq_ack_i = 1'b1;
      tick();
      irq_ack_i = 1'b0;
      chk("R7 ack clears", {7'b0, reg_rdata_o[4]}, 8'h00);
      // R11 write-one collides with event
      wr(8'h10);
      cmp_raw_i = 1'b1;
      tick(2);
      wr(8'h18);
      chk("R11 w1c vs event", {7'b0, reg_rdata_o[4]}, 8'h01);
      wr(8'h10);
      gie_i = 1'b0;
      tick(2);

      // R12 hold while powered down; raw is 1
      cmp_raw_i = 1'b0;
      tick(4);
      wr(8'h10);
      wr(8'h80);
      chk("R10 pwrdn", {7'b0, cmp_pwrdn_o}, 8'h01);
      cmp_raw_i = 1'b1;
      tick(5);
      chk("R12 level held", {7'b0, reg_rdata_o[5]}, 8'h00);
      chk("R12 no flag while off", {7'b0, reg_rdata_o[4]}, 8'h00);
      cmp_raw_i = 1'b0;
      tick(3);
      wr(8'h00);
      tick(4);
      chk("R12 no flag on resume", {7'b0, reg_rdata_o[4]}, 8'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule